// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronized Halt

This block produces the count-enable pulses for three timer/counters from one system clock. A 10-bit prescaler counter advances on every clock and supplies divided taps. Each timer has its own 3-bit source select. The select chooses one of these sources: no counting, every clock, one of four divided rates, or an edge on that timer's external pin after synchronization. Each timer gets a single-cycle enable pulse on its own output, and it advances its count when that pulse is high.

A small control register lets software restart the prescaler. Outside synchronization mode, a restart request lasts one cycle and then clears itself. With the synchronization bit set, a restart request stays set. While it is set the prescaler stays at zero and every timer enable is held low, so software can load all timers without any of them moving. When software clears the synchronization bit, the hardware drops both restart requests in the same write. All timers then start on the same clock, with the same prescaler phase. A second restart bit belongs to a prescaler outside this block. It follows the same sticky rules and is only driven out on a pin.

Top module: `timer_prescaler_hub`

## Requirements
- R1: While `rst_n` is low, every `cnt_en` bit is 0. After reset, `ctrl_rdata` reads 0x00.
- R2: A timer whose select is 000 never gets an enable pulse.
- R3: A timer whose select is 001 gets an enable on every cycle in which the shared prescaler is not being restarted.
- R4: Selects 010, 011, 100 and 101 divide by 8, 64, 256 and 1024. Cycle 0 is the first cycle after a restart ends. The first pulse comes in cycle N-1, and after that there is exactly one pulse every N cycles.
- R5: Outside synchronization mode, writing 1 to control bit 0 holds the shared prescaler at zero for one cycle. In that cycle every enable is 0 and bit 0 reads back 1. On the next cycle bit 0 reads back 0.
- R6: While control bit 7 (synchronization mode) is 1, any restart bit written as 1 stays set and reads back as 1. While bit 0 is set, every `cnt_en` bit stays 0.
- R7: Writing bit 7 as 0 with bits 1:0 as 0 clears both restart bits in that write. The timers then start on the same cycle: a timer on select 001 pulses in cycle 0, and timers that share a divided select pulse together in cycle N-1.
- R8: Control bit 1 drives `alt_ps_clr`, with the same sticky and self-clearing rules as bit 0. It has no effect on `cnt_en`.
- R9: Select 111 gives one pulse per rising edge of the timer's pin. The pulse comes in the cycle after the second clock edge that follows the transition. Falling edges give no pulse.
- R10: Select 110 gives one pulse per falling edge of the pin, with the same latency. Rising edges give no pulse.
- R11: For a pin whose half periods last at least two clocks, the external path is never divided: it gives exactly one pulse per selected edge, and never on two cycles in a row.
- R12: Control bits 6:2 are ignored on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data (bit 7 sync mode, bit 1 other restart, bit 0 shared restart) |
| ctrl_rdata | output | 8 | Control register read-back |
| csel | input | 3*NUM_TIMERS | Per-timer source select, timer i at bits 3i+2:3i |
| ext_pin | input | NUM_TIMERS | Per-timer external clock pins, asynchronous |
| cnt_en | output | NUM_TIMERS | Per-timer single-cycle count enables |
| alt_ps_clr | output | 1 | Restart request for the other prescaler |

## Verification
The bench builds the block with its defaults: a 10-bit prescaler, three timers and a two-flop synchronizer. With a 10-bit prescaler, even the divide-by-1024 period fits inside one window of the vector walk. This lets the bench check both the cycle of the first pulse and a window one cycle shorter that must stay empty, for every tap. With three timers, two timers can sit on one divided tap while a third runs on every clock. The bench uses this to confirm the shared release across taps. It also drives the rising and falling external paths at once, so each can be seen ignoring the other's edge.

// File: rtl/tpre_pkg.sv
package tpre_pkg;

  typedef enum logic [2:0] {
    CS_OFF      = 3'b000,
    CS_SYS      = 3'b001,
    CS_D8       = 3'b010,
    CS_D64      = 3'b011,
    CS_D256     = 3'b100,
    CS_D1024    = 3'b101,
    CS_EXT_FALL = 3'b110,
    CS_EXT_RISE = 3'b111
  } csel_e;

  localparam int NUM_TAPS      = 4;
  localparam int SEL_W         = 3;
  localparam int CTRL_W        = 8;
  localparam int BIT_SYNC      = 7;
  localparam int BIT_ALT_CLR   = 1;
  localparam int BIT_MAIN_CLR  = 0;

  // log2 of the divisor for tap k: 8, 64, 256, 1024
  function automatic int tap_log2(input int k);
    case (k)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tpre_ctrl.sv
module tpre_ctrl
  import tpre_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic              main_clr,
  output logic              alt_clr,
  output logic [CTRL_W-1:0] rdata
);

  logic       sync_q;
  logic [1:0] clr_q;
  logic [1:0] wr_clr;

  assign wr_clr = {wdata[BIT_ALT_CLR], wdata[BIT_MAIN_CLR]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      clr_q  <= 2'b00;
    end else if (we) begin
      sync_q <= wdata[BIT_SYNC];
      // sticky accumulate in sync mode; otherwise a one-cycle request
      clr_q  <= wdata[BIT_SYNC] ? (clr_q | wr_clr) : wr_clr;
    end else if (!sync_q) begin
      clr_q  <= 2'b00;
    end
  end

  assign main_clr = clr_q[0];
  assign alt_clr  = clr_q[1];

  always_comb begin
    rdata               = '0;
    rdata[BIT_SYNC]     = sync_q;
    rdata[BIT_ALT_CLR]  = clr_q[1];
    rdata[BIT_MAIN_CLR] = clr_q[0];
  end

endmodule

// File: rtl/tpre_counter.sv
module tpre_counter
  import tpre_pkg::*;
#(
  parameter int PS_WIDTH = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  output logic [NUM_TAPS-1:0] taps
);

  logic [PS_WIDTH-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // a tap fires on the last count before its low bits wrap to zero
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam int L = tap_log2(k);
    assign taps[k] = &cnt_q[L-1:0];
  end

endmodule

// File: rtl/tpre_ext_edge.sv
module tpre_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[TOP-1:0], pin};
      prev_q <= sync_q[TOP];
    end
  end

  assign rise = sync_q[TOP] & ~prev_q;
  assign fall = ~sync_q[TOP] & prev_q;

endmodule

// File: rtl/tpre_select.sv
module tpre_select
  import tpre_pkg::*;
(
  input  logic [SEL_W-1:0]    sel,
  input  logic [NUM_TAPS-1:0] taps,
  input  logic                ext_rise,
  input  logic                ext_fall,
  input  logic                hold,
  output logic                en
);

  logic pick;

  always_comb begin
    case (csel_e'(sel))
      CS_OFF:      pick = 1'b0;
      CS_SYS:      pick = 1'b1;
      CS_D8:       pick = taps[0];
      CS_D64:      pick = taps[1];
      CS_D256:     pick = taps[2];
      CS_D1024:    pick = taps[3];
      CS_EXT_FALL: pick = ext_fall;
      CS_EXT_RISE: pick = ext_rise;
      default:     pick = 1'b0;
    endcase
    en = pick & ~hold;
  end

endmodule

// File: rtl/timer_prescaler_hub.sv
module timer_prescaler_hub
  import tpre_pkg::*;
#(
  parameter int NUM_TIMERS  = 3,
  parameter int PS_WIDTH    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ctrl_we,
  input  logic [7:0]                  ctrl_wdata,
  output logic [7:0]                  ctrl_rdata,
  input  logic [SEL_W*NUM_TIMERS-1:0] csel,
  input  logic [NUM_TIMERS-1:0]       ext_pin,
  output logic [NUM_TIMERS-1:0]       cnt_en,
  output logic                        alt_ps_clr
);

  logic                main_clr;
  logic                hold;
  logic [NUM_TAPS-1:0] taps;

  tpre_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ctrl_we),
    .wdata    (ctrl_wdata),
    .main_clr (main_clr),
    .alt_clr  (alt_ps_clr),
    .rdata    (ctrl_rdata)
  );

  tpre_counter #(.PS_WIDTH(PS_WIDTH)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (main_clr),
    .taps  (taps)
  );

  assign hold = main_clr | ~rst_n;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_timer
    logic rise, fall;

    tpre_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_pin[i]),
      .rise  (rise),
      .fall  (fall)
    );

    tpre_select u_sel (
      .sel      (csel[SEL_W*i +: SEL_W]),
      .taps     (taps),
      .ext_rise (rise),
      .ext_fall (fall),
      .hold     (hold),
      .en       (cnt_en[i])
    );
  end

endmodule

// File: rtl/tpre_checker.sv
module tpre_checker #(
  parameter int NUM_TIMERS = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ctrl_we,
  input logic [7:0]              ctrl_wdata,
  input logic [7:0]              ctrl_rdata,
  input logic [3*NUM_TIMERS-1:0] csel,
  input logic [NUM_TIMERS-1:0]   cnt_en
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> cnt_en == '0);

  assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[0] |-> cnt_en == '0);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[7] && !ctrl_we) |=> $stable(ctrl_rdata));

  assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rdata[7] && !ctrl_we) |=> ctrl_rdata[1:0] == 2'b00);

  assert_exit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ctrl_wdata[7] && ctrl_wdata[1:0] == 2'b00) |=> ctrl_rdata == 8'h00);

  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[6:2] == 5'b0);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_t
    assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      csel[3*i +: 3] == 3'b000 |-> !cnt_en[i]);

    assert_every_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (csel[3*i +: 3] == 3'b001 && !ctrl_rdata[0]) |-> cnt_en[i]);

    assert_ext_spaced_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (csel[3*i+1 +: 2] == 2'b11 && cnt_en[i])
        |=> (!cnt_en[i] || csel[3*i +: 3] != $past(csel[3*i +: 3])));
  end

endmodule

bind timer_prescaler_hub tpre_checker #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_we    (ctrl_we),
  .ctrl_wdata (ctrl_wdata),
  .ctrl_rdata (ctrl_rdata),
  .csel       (csel),
  .cnt_en     (cnt_en)
);

// File: tb/tb_timer_prescaler_hub.sv
module tb_timer_prescaler_hub;

  localparam int NT = 3;
  localparam int NV = 10;

  // vector table: select applied to all timers, window length, expected pulses
  localparam logic [2:0] V_SEL [NV] = '{3'b000, 3'b001, 3'b010, 3'b010, 3'b011,
                                        3'b011, 3'b100, 3'b100, 3'b101, 3'b101};
  localparam int V_WIN [NV] = '{40, 40, 64, 7, 128, 63, 256, 255, 1024, 1023};
  localparam int V_EXP [NV] = '{0, 40, 8, 0, 2, 0, 1, 0, 1, 0};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctrl_we;
  logic [7:0]    ctrl_wdata;
  logic [7:0]    ctrl_rdata;
  logic [3*NT-1:0] csel;
  logic [NT-1:0] ext_pin;
  logic [NT-1:0] cnt_en;
  logic          alt_ps_clr;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  timer_prescaler_hub dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .csel       (csel),
    .ext_pin    (ext_pin),
    .cnt_en     (cnt_en),
    .alt_ps_clr (alt_ps_clr)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // drive a write; returns at the first negedge after the write takes effect
  task automatic wr(input logic [7:0] d);
    ctrl_we    = 1'b1;
    ctrl_wdata = d;
    tick();
    ctrl_we    = 1'b0;
    ctrl_wdata = 8'h00;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n0, n2, nr, nf, n2x;
    logic [NT-1:0] last;
    rst_n = 1'b0; ctrl_we = 1'b0; ctrl_wdata = 8'h00;
    csel = {3'b001, 3'b001, 3'b001}; ext_pin = '0;
    repeat (3) tick();
    chk("R1 enables in reset", cnt_en, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 ctrl after reset", ctrl_rdata, 0);

    // vector walk: restart prescaler, then count pulses over a window
    for (int v = 0; v < NV; v++) begin
      csel = {V_SEL[v], V_SEL[v], V_SEL[v]};
      wr(8'h01);
      chk("R5 enables held in restart cycle", cnt_en, 0);
      chk("R5 restart bit reads 1", ctrl_rdata, 8'h01);
      n0 = 0; n2 = 0;
      for (int c = 0; c < V_WIN[v]; c++) begin
        tick();
        if (c == 0) chk("R5 restart bit self-cleared", ctrl_rdata, 0);
        n0 += int'(cnt_en[0]);
        n2 += int'(cnt_en[2]);
      end
      chk($sformatf("R4 R3 R2 timer0 sel=%0d win=%0d", V_SEL[v], V_WIN[v]), n0, V_EXP[v]);
      chk($sformatf("R4 timer2 sel=%0d win=%0d", V_SEL[v], V_WIN[v]), n2, V_EXP[v]);
    end

    // sync mode hold and simultaneous release
    csel = {3'b010, 3'b001, 3'b010};
    wr(8'h83);
    chk("R6 sticky bits read back", ctrl_rdata, 8'h83);
    chk("R8 alt clear asserted", alt_ps_clr, 1);
    for (int c = 0; c < 20; c++) begin
      chk("R6 enables frozen", cnt_en, 0);
      tick();
    end
    chk("R6 bits still set", ctrl_rdata, 8'h83);
    wr(8'h00);
    chk("R7 bits cleared on exit", ctrl_rdata, 0);
    chk("R7 alt clear released", alt_ps_clr, 0);
    chk("R7 sys-clock timer starts in cycle 0", cnt_en, 3'b010);
    for (int c = 1; c < 8; c++) begin
      tick();
      if (c < 7) chk("R7 no tap before N-1", cnt_en, 3'b010);
      else       chk("R7 tap timers pulse together", cnt_en, 3'b111);
    end

    // other prescaler restart bit outside sync mode
    csel = {3'b000, 3'b000, 3'b001};
    wr(8'h02);
    chk("R8 alt clear pulse", alt_ps_clr, 1);
    chk("R8 no effect on enables", cnt_en, 3'b001);
    tick();
    chk("R8 alt clear self-cleared", alt_ps_clr, 0);

    // reserved bits
    wr(8'h7C);
    chk("R12 reserved bits read 0", ctrl_rdata, 0);

    // external edges: timer0 rising, timer1 falling, timer2 stopped
    csel = {3'b000, 3'b110, 3'b111};
    ext_pin = '0;
    repeat (4) tick();
    ext_pin = 3'b111;
    tick(); chk("R9 no pulse one edge after rise", cnt_en, 0);
    tick(); chk("R9 rise pulse after second edge", cnt_en, 3'b001);
    tick(); chk("R9 single rise pulse", cnt_en, 0);
    ext_pin = 3'b000;
    tick(); chk("R10 no pulse one edge after fall", cnt_en, 0);
    tick(); chk("R10 fall pulse after second edge", cnt_en, 3'b010);
    tick(); chk("R10 single fall pulse", cnt_en, 0);

    nr = 0; nf = 0; n2x = 0; last = '0;
    for (int p = 0; p < 10; p++) begin
      for (int h = 0; h < 4; h++) begin
        if (h == 0) ext_pin = 3'b111;
        if (h == 2) ext_pin = 3'b000;
        tick();
        nr += int'(cnt_en[0]); nf += int'(cnt_en[1]); n2x += int'(cnt_en[2]);
        if ((cnt_en[1:0] & last[1:0]) != 2'b00)
          chk("R11 back-to-back pulse", int'(cnt_en[1:0] & last[1:0]), 0);
        last = cnt_en;
      end
    end
    repeat (4) begin
      tick();
      nr += int'(cnt_en[0]); nf += int'(cnt_en[1]); n2x += int'(cnt_en[2]);
    end
    chk("R11 R9 one pulse per rising edge", nr, 10);
    chk("R11 R10 one pulse per falling edge", nf, 10);
    chk("R2 stopped timer ignores pin", n2x, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule